// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block runs the DMA side of a sector-oriented disk controller's data path. A small byte FIFO sits between the host, which moves data one byte per acknowledged strobe, and the media side, which moves one byte per `media_tick`. The sequencer raises a DMA request when the FIFO holds enough bytes for the host to service. For reads that means enough bytes to drain, and for writes enough free space to fill. It counts the bytes of each sector on the media side and steps the sector number up to a programmed last sector.

A transfer ends in one of three ways. The host can end it with a terminal count, which counts only while its acknowledge is active. The media side can reach the end of the last sector. The FIFO can underrun on a write or overrun on a read. When the host stops partway through a sector, the controller completes that sector by itself. On writes it sends the bytes still queued and then zero bytes. On reads it throws the remaining bytes away. Every way of ending reports the same abnormal-termination result code, together with a cause code that separates them.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `busy`, `dma_req` and `done` are 0 and `result` is 2'b00 (none). `dma_req` is never 1 while `busy` is 0.
- R2: While transferring, `dma_req` is 1 exactly when the serviceable level is at least max(`thresh`,1). On reads the level is the FIFO fill, and on writes it is DEPTH minus the fill.
- R3: A terminal count takes effect only in a cycle where both `tc` and `dma_ack` are 1. A byte strobed in that cycle is still transferred, and `dma_req` is 0 from the next cycle on. A `tc` without `dma_ack` changes nothing.
- R4: Bytes leave the FIFO in the order they entered, in both directions. A host byte and a media byte may move in the same cycle.
- R5: Every SECTOR_BYTES media bytes, `sector_now` advances from `first_sector` until it equals `eot_sector`. A write ends on the media byte that completes that sector. A read moves on to a drain phase and ends once the host has emptied the FIFO.
- R6: After a terminal count in mid-sector, the media side continues to the sector boundary and the transfer ends there. On writes, the queued bytes go out first, followed by zero bytes on `media_wdata`. On reads, the FIFO is cleared and the later media bytes are discarded.
- R7: On a read, a `media_tick` that arrives while the FIFO holds DEPTH bytes ends the transfer with cause 2'b11.
- R8: On a write, a `media_tick` that arrives while the FIFO is empty, before any terminal count, ends the transfer with cause 2'b11.
- R9: When a transfer ends, `done` pulses for exactly one cycle and `busy` falls in the same cycle. `result` becomes 2'b10 (abnormal) and `cause` becomes 2'b01 for a terminal count, 2'b10 for end of track or 2'b11 for a FIFO fault. Both hold until the next accepted `start`, which returns them to 2'b00.
- R10: If a terminal count arrives in the same cycle as the media byte that ends a sector, the transfer ends at that boundary with cause 2'b01, even when that sector is the last one.
- R11: A `start` pulse while `busy` is 1 is ignored. The configuration and the sector number stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| dir_write | input | 1 | 1 = host-to-media write, 0 = media-to-host read |
| thresh | input | $clog2(DEPTH) | Request threshold (0 acts as 1) |
| first_sector | input | SW | Sector number to start from |
| eot_sector | input | SW | Last sector of the transfer |
| dma_req | output | 1 | DMA request to the host |
| dma_ack | input | 1 | DMA acknowledge from the host |
| host_strobe | input | 1 | Host byte strobe (counts with `dma_ack`) |
| tc | input | 1 | Terminal count (counts with `dma_ack`) |
| host_wdata | input | 8 | Host byte for writes |
| host_rdata | output | 8 | FIFO head byte for reads |
| media_tick | input | 1 | One media-side byte time |
| media_rdata | input | 8 | Media byte for reads |
| media_wdata | output | 8 | Byte sent to media on writes (zero when padding) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | 2 | 00 none, 10 abnormal termination |
| cause | output | 2 | 01 terminal count, 10 end of track, 11 FIFO fault |
| sector_now | output | SW | Current sector number |

## Verification
Two events can land in the same clock cycle: a terminal count from the host and the media byte that closes a sector. To force this, the bench primes a write FIFO so that exactly one byte of the last sector is still queued. It then drives `tc` with `dma_ack`, an extra host strobe and the final `media_tick` in one cycle. The result is judged correct if `done` rises after that edge with the terminal-count cause rather than end of track, and if the extra host byte never reaches the media side. The steady-state runs also overlap host and media byte moves in single cycles, and the scoreboard checks that byte order survives them.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        RES_NONE     = 2'b00,
        RES_NORMAL   = 2'b01,
        RES_ABNORMAL = 2'b10
    } result_e;

    typedef enum logic [1:0] {
        END_NONE = 2'b00,
        END_TC   = 2'b01,
        END_EOT  = 2'b10,
        END_FIFO = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_XFER  = 2'b01,
        ST_DRAIN = 2'b10
    } state_e;

    typedef struct packed {
        logic              flush;
        logic              push;
        logic              pop;
        logic [DATA_W-1:0] data;
    } fifo_op_t;

    // Level test against a threshold where zero behaves as one.
    function automatic logic meets_thr(input logic [7:0] level, input logic [7:0] thr);
        logic [7:0] eff;
        eff = (thr == 8'd0) ? 8'd1 : thr;
        return level >= eff;
    endfunction

endpackage

// File: rtl/dxs_fifo.sv
module dxs_fifo
    import dxs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  fifo_op_t                       op,
    output logic [DATA_W-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_p;
    logic [AW-1:0]     rd_p;
    logic              do_pop;
    logic              do_push;

    assign do_pop  = op.pop && (count != '0);
    assign do_push = op.push && ((count != CW'(DEPTH)) || do_pop);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_p  <= '0;
            rd_p  <= '0;
            count <= '0;
        end else begin
            if (do_push) wr_p <= bump(wr_p);
            if (do_pop)  rd_p <= bump(rd_p);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !op.flush) mem[wr_p] <= op.data;
    end

    assign head = (count == '0) ? '0 : mem[rd_p];

endmodule

// File: rtl/dxs_pos.sv
module dxs_pos #(
    parameter int SECTOR_BYTES = 512,
    parameter int SW           = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] first,
    input  logic [SW-1:0] last,
    input  logic          step,
    output logic [SW-1:0] sector,
    output logic          at_last,
    output logic          on_eot
);
    localparam int BW = $clog2(SECTOR_BYTES);

    logic [BW-1:0] byte_q;
    logic [SW-1:0] eot_q;

    assign at_last = (byte_q == BW'(SECTOR_BYTES - 1));
    assign on_eot  = (sector == eot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            sector <= '0;
            eot_q  <= '0;
        end else if (load) begin
            byte_q <= '0;
            sector <= first;
            eot_q  <= last;
        end else if (step) begin
            if (at_last) begin
                byte_q <= '0;
                if (!on_eot) sector <= sector + 1'b1;
            end else begin
                byte_q <= byte_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dxs_ctrl.sv
module dxs_ctrl
    import dxs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        dir_write,
    input  logic [$clog2(DEPTH)-1:0]    thresh,
    input  logic                        host_strobe,
    input  logic                        dma_ack,
    input  logic                        tc,
    input  logic                        media_tick,
    input  logic [DATA_W-1:0]           host_wdata,
    input  logic [DATA_W-1:0]           media_rdata,
    input  logic [$clog2(DEPTH+1)-1:0]  fifo_cnt,
    input  logic                        at_last,
    input  logic                        on_eot,
    output fifo_op_t                    fop,
    output logic                        pos_step,
    output logic                        pos_load,
    output logic                        dma_req,
    output logic                        busy,
    output logic                        done,
    output result_e                     result,
    output cause_e                      cause,
    output logic                        dir_lat
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int TW = $clog2(DEPTH);

    state_e        st_q;
    logic          stop_q;
    logic          done_q;
    logic [TW-1:0] thr_q;
    result_e       res_q;
    cause_e        cause_q;

    logic          active, empty, full;
    logic [CW-1:0] level;
    logic          host_xfer, tc_hit, media_act, fault, edge_step;
    logic          fin, to_drain, accept;
    cause_e        why;

    assign active    = (st_q != ST_IDLE);
    assign empty     = (fifo_cnt == '0);
    assign full      = (fifo_cnt == CW'(DEPTH));
    assign level     = dir_lat ? (CW'(DEPTH) - fifo_cnt) : fifo_cnt;
    assign host_xfer = active && !stop_q && host_strobe && dma_ack;
    assign tc_hit    = active && !stop_q && tc && dma_ack;
    assign media_act = (st_q == ST_XFER) && media_tick;
    assign fault     = media_act && !stop_q && (dir_lat ? empty : full);
    assign edge_step = media_act && !fault && at_last;
    assign accept    = (st_q == ST_IDLE) && start;

    // Ending priority: FIFO fault, then host stop at a boundary, then end of track.
    always_comb begin
        fin = 1'b0;
        why = END_NONE;
        if (fault) begin
            fin = 1'b1;
            why = END_FIFO;
        end else if (edge_step && (stop_q || tc_hit)) begin
            fin = 1'b1;
            why = END_TC;
        end else if (edge_step && on_eot && dir_lat) begin
            fin = 1'b1;
            why = END_EOT;
        end else if ((st_q == ST_DRAIN) && tc_hit) begin
            fin = 1'b1;
            why = END_TC;
        end else if ((st_q == ST_DRAIN) && empty) begin
            fin = 1'b1;
            why = END_EOT;
        end
    end

    assign to_drain = edge_step && on_eot && !dir_lat && !fin;

    always_comb begin
        fop.flush = accept || fin || (!dir_lat && (tc_hit || stop_q));
        fop.push  = dir_lat ? host_xfer : (media_act && !stop_q && !fault);
        fop.pop   = dir_lat ? (media_act && !empty && !fault) : host_xfer;
        fop.data  = dir_lat ? host_wdata : media_rdata;
    end

    assign pos_step = media_act && !fault;
    assign pos_load = accept;

    assign dma_req = !stop_q &&
                     (((st_q == ST_XFER) && meets_thr(8'(level), 8'(thr_q))) ||
                      ((st_q == ST_DRAIN) && !empty));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            dir_lat <= 1'b0;
            stop_q  <= 1'b0;
            thr_q   <= '0;
            done_q  <= 1'b0;
            res_q   <= RES_NONE;
            cause_q <= END_NONE;
        end else begin
            done_q <= fin;
            if (st_q == ST_IDLE) begin
                if (start) begin
                    st_q    <= ST_XFER;
                    dir_lat <= dir_write;
                    thr_q   <= thresh;
                    stop_q  <= 1'b0;
                    res_q   <= RES_NONE;
                    cause_q <= END_NONE;
                end
            end else if (fin) begin
                st_q    <= ST_IDLE;
                stop_q  <= 1'b0;
                res_q   <= RES_ABNORMAL;
                cause_q <= why;
            end else begin
                if (tc_hit)   stop_q <= 1'b1;
                if (to_drain) st_q   <= ST_DRAIN;
            end
        end
    end

    assign busy   = active;
    assign done   = done_q;
    assign result = res_q;
    assign cause  = cause_q;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dxs_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int SECTOR_BYTES = 512,
    parameter int SW           = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      dir_write,
    input  logic [$clog2(DEPTH)-1:0]  thresh,
    input  logic [SW-1:0]             first_sector,
    input  logic [SW-1:0]             eot_sector,
    output logic                      dma_req,
    input  logic                      dma_ack,
    input  logic                      host_strobe,
    input  logic                      tc,
    input  logic [7:0]                host_wdata,
    output logic [7:0]                host_rdata,
    input  logic                      media_tick,
    input  logic [7:0]                media_rdata,
    output logic [7:0]                media_wdata,
    output logic                      busy,
    output logic                      done,
    output logic [1:0]                result,
    output logic [1:0]                cause,
    output logic [SW-1:0]             sector_now
);
    localparam int CW = $clog2(DEPTH + 1);

    fifo_op_t          fop;
    logic [DATA_W-1:0] fifo_head;
    logic [CW-1:0]     fifo_cnt;
    logic              pos_step, pos_load, at_last, on_eot;
    logic              dir_lat;
    result_e           res_e;
    cause_e            cause_v;

    dxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .op    (fop),
        .head  (fifo_head),
        .count (fifo_cnt)
    );

    dxs_pos #(.SECTOR_BYTES(SECTOR_BYTES), .SW(SW)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .load    (pos_load),
        .first   (first_sector),
        .last    (eot_sector),
        .step    (pos_step),
        .sector  (sector_now),
        .at_last (at_last),
        .on_eot  (on_eot)
    );

    dxs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dir_write   (dir_write),
        .thresh      (thresh),
        .host_strobe (host_strobe),
        .dma_ack     (dma_ack),
        .tc          (tc),
        .media_tick  (media_tick),
        .host_wdata  (host_wdata),
        .media_rdata (media_rdata),
        .fifo_cnt    (fifo_cnt),
        .at_last     (at_last),
        .on_eot      (on_eot),
        .fop         (fop),
        .pos_step    (pos_step),
        .pos_load    (pos_load),
        .dma_req     (dma_req),
        .busy        (busy),
        .done        (done),
        .result      (res_e),
        .cause       (cause_v),
        .dir_lat     (dir_lat)
    );

    assign result      = res_e;
    assign cause       = cause_v;
    assign host_rdata  = fifo_head;
    assign media_wdata = dir_lat ? fifo_head : 8'h00;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int DEPTH = 16,
    parameter int SW    = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         tc,
    input logic                         dma_ack,
    input logic                         media_tick,
    input logic                         dma_req,
    input logic                         done,
    input logic                         busy,
    input logic [1:0]                   result,
    input logic [1:0]                   cause,
    input logic [SW-1:0]                sector_now,
    input logic [$clog2(DEPTH+1)-1:0]   fifo_cnt,
    input logic [7:0]                   media_wdata,
    input logic                         dir_lat
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dma_req);

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && tc && dma_ack) |=> !dma_req);

    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && dir_lat && (fifo_cnt == '0)) |-> (media_wdata == 8'h00));

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_result_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && (result == 2'b10) && (cause != 2'b00)));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !media_tick) |=> $stable(sector_now));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.DEPTH(DEPTH), .SW(SW)) u_chk (.*);

// File: tb/sim_dma_xfer_seq.sv
`timescale 1ns/1ps
module sim_dma_xfer_seq;
    localparam int DEPTH = 16;
    localparam int SB    = 32;
    localparam int SW    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, dir_write = 0, dma_ack = 0, host_strobe = 0, tc = 0, media_tick = 0;
    logic [3:0] thresh = '0;
    logic [SW-1:0] first_sector = '0, eot_sector = '0;
    logic [7:0] host_wdata = '0, media_rdata = '0;
    logic dma_req, busy, done;
    logic [7:0] host_rdata, media_wdata;
    logic [1:0] result, cause;
    logic [SW-1:0] sector_now;

    int checks = 0;
    int errors = 0;
    int mode = 0;       // 0 off, 1 media-side writes, 2 host-side reads
    int cyc_all = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    dma_xfer_seq #(.DEPTH(DEPTH), .SECTOR_BYTES(SB), .SW(SW)) u0 (
        .clk(clk), .rst(rst), .start(start), .dir_write(dir_write), .thresh(thresh),
        .first_sector(first_sector), .eot_sector(eot_sector), .dma_req(dma_req),
        .dma_ack(dma_ack), .host_strobe(host_strobe), .tc(tc), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .media_tick(media_tick), .media_rdata(media_rdata),
        .media_wdata(media_wdata), .busy(busy), .done(done), .result(result),
        .cause(cause), .sector_now(sector_now));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 13 + s) & 255);
    endfunction

    task automatic step(input logic st, input logic hs, input logic ak, input logic t,
                        input logic [7:0] wd, input logic mt, input logic [7:0] md);
        start = st; host_strobe = hs; dma_ack = ak; tc = t;
        host_wdata = wd; media_tick = mt; media_rdata = md;
        @(posedge clk); #1;
        start = 0; host_strobe = 0; dma_ack = 0; tc = 0; media_tick = 0;
    endtask

    // Scoreboard monitor: R4 byte order on both sides
    always @(negedge clk) begin
        if (mode == 1 && media_tick && busy) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 media byte %0h with no expected byte", media_wdata);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (media_wdata !== e) begin
                    errors++;
                    $display("FAIL R4 media byte actual=%0h expected=%0h", media_wdata, e);
                end
            end
        end
        if (mode == 2 && host_strobe && dma_ack && dma_req) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 host byte %0h with no expected byte", host_rdata);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL R4 host byte actual=%0h expected=%0h", host_rdata, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_all);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sent, ticks, cyc;
        logic fin;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 dma_req", dma_req, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 2'b00);

        // ---- write, two sectors, end of track (R2 R4 R5 R9)
        dir_write = 1; thresh = 4; first_sector = 0; eot_sector = 1; mode = 1;
        step(1, 0, 0, 0, 0, 0, 0);
        check("R9 result cleared", result, 2'b00);
        check("R2 write req empty fifo", dma_req, 1);
        for (int i = 0; i < 12; i++) begin
            exp_q.push_back(pat(i, 1));
            step(0, 1, 1, 0, pat(i, 1), 0, 0);
        end
        check("R2 write req at free=4", dma_req, 1);
        exp_q.push_back(pat(12, 1));
        step(0, 1, 1, 0, pat(12, 1), 0, 0);
        check("R2 write req at free=3", dma_req, 0);
        sent = 13; ticks = 0; cyc = 0; fin = 0;
        while (!fin && cyc < 3000) begin
            logic s, m;
            s = dma_req && (sent < 64);
            m = cyc[0];
            if (s) exp_q.push_back(pat(sent, 1));
            step(0, s, s, 0, pat(sent, 1), m, 0);
            if (s) sent++;
            if (m) begin
                ticks++;
                if (ticks == 32) check("R5 sector advance", sector_now, 1);
            end
            fin = done;
            cyc++;
        end
        check("R5 write ends on last byte", ticks, 64);
        check("R9 busy low at done", busy, 0);
        check("R9 result abnormal", result, 2'b10);
        check("R9 cause eot", cause, 2'b10);
        check("R5 sector at eot", sector_now, 1);
        check("R4 write queue drained", exp_q.size(), 0);
        step(0, 0, 0, 0, 0, 0, 0);
        check("R9 done one cycle", done, 0);
        check("R9 result held", result, 2'b10);

        // ---- read, one sector, drain then end (R2 R4 R5)
        dir_write = 0; thresh = 8; first_sector = 3; eot_sector = 3; mode = 2;
        step(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) begin
            exp_q.push_back(pat(i, 5));
            step(0, 0, 0, 0, 0, 1, pat(i, 5));
        end
        check("R2 read req below thr", dma_req, 0);
        exp_q.push_back(pat(7, 5));
        step(0, 0, 0, 0, 0, 1, pat(7, 5));
        check("R2 read req at thr", dma_req, 1);
        ticks = 8; cyc = 0; fin = 0;
        while (!fin && cyc < 2000) begin
            logic s, m;
            m = ticks < 32;
            s = dma_req;
            if (m) exp_q.push_back(pat(ticks, 5));
            step(0, s, s, 0, 0, m, pat(ticks, 5));
            if (m) ticks++;
            fin = done;
            cyc++;
        end
        check("R5 read done", fin, 1);
        check("R9 read cause eot", cause, 2'b10);
        check("R5 read sector", sector_now, 3);
        check("R4 read queue drained", exp_q.size(), 0);

        // ---- read, host stops mid-sector (R3 R6)
        dir_write = 0; thresh = 1; first_sector = 0; eot_sector = 5; mode = 2;
        step(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(pat(i, 9));
            step(0, 0, 0, 0, 0, 1, pat(i, 9));
        end
        step(0, 1, 1, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0);
        step(0, 1, 1, 1, 0, 0, 0);
        check("R3 read req dropped after tc", dma_req, 0);
        exp_q.delete();
        mode = 0;
        for (int i = 0; i < 26; i++) step(0, 0, 0, 0, 0, 1, 8'h55);
        check("R6 read still completing sector", busy, 1);
        step(0, 0, 0, 0, 0, 1, 8'h55);
        check("R6 read ends at boundary", done, 1);
        check("R9 read cause tc", cause, 2'b01);

        // ---- write, host stops mid-sector, zero padding (R3 R6)
        dir_write = 1; thresh = 1; first_sector = 0; eot_sector = 5; mode = 1;
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        check("R3 tc without ack keeps req", dma_req, 1);
        check("R3 tc without ack keeps busy", busy, 1);
        for (int i = 0; i < 10; i++) begin
            exp_q.push_back(pat(i, 17));
            step(0, 1, 1, (i == 9), pat(i, 17), 0, 0);
        end
        check("R3 write req dropped after tc", dma_req, 0);
        for (int i = 0; i < 22; i++) exp_q.push_back(8'h00);
        for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0, 1, 0);
        check("R6 write still padding", busy, 1);
        step(0, 0, 0, 0, 0, 1, 0);
        check("R6 write ends at boundary", done, 1);
        check("R9 write cause tc", cause, 2'b01);
        check("R6 pad bytes all sent", exp_q.size(), 0);

        // ---- tc and last sector byte in one cycle (R10)
        dir_write = 1; thresh = 1; first_sector = 0; eot_sector = 0; mode = 1;
        step(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            exp_q.push_back(pat(i, 23));
            step(0, 1, 1, 0, pat(i, 23), 0, 0);
        end
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1, 0);
        for (int i = 16; i < 32; i++) begin
            exp_q.push_back(pat(i, 23));
            step(0, 1, 1, 0, pat(i, 23), 0, 0);
        end
        for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 0, 1, 0);
        step(0, 1, 1, 1, 8'hEE, 1, 0);
        check("R10 same-cycle end", done, 1);
        check("R10 tc wins over eot", cause, 2'b01);
        check("R10 no extra byte", exp_q.size(), 0);
        mode = 0;

        // ---- read overrun, start while busy ignored (R7 R11)
        dir_write = 0; thresh = 15; first_sector = 2; eot_sector = 5;
        step(1, 0, 0, 0, 0, 0, 0);
        first_sector = 9; dir_write = 1;
        step(1, 0, 0, 0, 0, 0, 0);
        check("R11 start ignored sector", sector_now, 2);
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1, 8'h11);
        check("R11 still read after ignored start", busy, 1);
        step(0, 0, 0, 0, 0, 1, 8'h11);
        check("R7 overrun ends", done, 1);
        check("R7 overrun cause", cause, 2'b11);

        // ---- write underrun (R8)
        dir_write = 1; thresh = 2; first_sector = 0; eot_sector = 0;
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        check("R8 underrun ends", done, 1);
        check("R8 underrun cause", cause, 2'b11);
        check("R8 busy low", busy, 0);

        step(0, 0, 0, 0, 0, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule